// File: doc/BRIEF.md
# SAR ADC conversion-and-readout controller

This block keeps a successive-approximation converter sampling at a steady rate and collects every result. An internal down-counter fires a sample event at a programmable period. On each event the block pulls an active-low conversion-start line for a programmable number of clocks. It then waits for the converter's busy line to drop, which means the conversion has ended. Only then does it select the converter and read the 16-bit result over a serial link. On that link it is the clock master, using SPI mode 1.

The serial clock comes from dividing the system clock by a parameter. The finished word is presented on a parallel bus with a one-cycle strobe. If busy never drops, a programmable timeout ends the attempt with an error pulse, and no read takes place. Sample events that arrive while an attempt is still in flight are dropped and counted.

Top module: `adc_sample_reader`

## Requirements
- R1: While rst_n is low: cnv_n=1, cs_n=1, sclk=0, sample_valid=0, timeout_err=0, overrun_count=0.
- R2: When idle, the block starts a conversion on each timer event. Timer events occur every max(period_cyc,1) clocks, and the first one falls on the first clock edge after reset is released. Consecutive cnv_n falling edges are therefore max(period_cyc,1) clocks apart when every event is accepted.
- R3: cnv_n stays low for exactly max(cnv_width,2) clocks per conversion.
- R4: cs_n goes low on the clock edge after the one where busy is first seen low in the wait phase. cs_n is never low while busy is high.
- R5: One read holds cs_n low for exactly 32*SCLK_HALF clocks. sclk makes exactly 16 rising edges in that time and is low whenever cs_n is high.
- R6: The result is shifted in MSB first. Each bit is sampled when sclk falls, and sample_data equals the 16-bit word the converter put out (bit 15 is the first bit on sdo).
- R7: sample_valid is a single-cycle pulse. It is high in the same cycle that cs_n returns high, and never on two cycles in a row.
- R8: If busy has not dropped, timeout_err pulses max(timeout_cyc,max(cnv_width,2))+1 clocks after cnv_n falls, and cs_n stays high for the whole attempt.
- R9: A timer event that arrives while the block is not idle starts nothing and adds one to overrun_count. The counter saturates at its all-ones value and never decreases.
- R10: The serial clock period is never shorter than ceil(CLK_HZ/17 MHz) system clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| period_cyc | input | TMR_W | Sample period in clocks (0 acts as 1) |
| cnv_width | input | PW_W | Conversion-start pulse width in clocks (values below 2 act as 2) |
| timeout_cyc | input | TMR_W | Clocks allowed from conversion start until busy must drop |
| busy | input | 1 | Converter busy, high during conversion |
| sdo | input | 1 | Serial data from the converter |
| cnv_n | output | 1 | Conversion start, active low |
| cs_n | output | 1 | Converter select, active low |
| sclk | output | 1 | Serial clock, idles low |
| sample_data | output | WORD_W | Last result read |
| sample_valid | output | 1 | One-cycle strobe marking a new result |
| timeout_err | output | 1 | One-cycle pulse when busy failed to drop in time |
| overrun_count | output | OVR_W | Saturating count of dropped timer events |

## Verification
The embedded properties check, on every clock, the rules that hold at any instant. These are: sclk stays quiet with cs_n high, cs_n never drops while busy is high, and the conversion-start pulse is at least two clocks long. They also check the sclk period against the 17 MHz ceiling, single-cycle strobes, no read on a timeout, and an overrun count that never falls. Only the bench scenarios can show the arithmetic results. That covers the exact pulse widths across a sweep of settings, event spacing, timeout latency for each width and limit pair, and the one-cycle gap from busy falling to select. It also covers bit-exact words for edge patterns and walking ones, and overrun totals that match the count of events minus accepted conversions, including saturation.

// File: rtl/adc_rd_pkg.sv
package adc_rd_pkg;
  typedef enum logic [1:0] {
    SEQ_IDLE  = 2'd0,
    SEQ_START = 2'd1,
    SEQ_WAIT  = 2'd2,
    SEQ_READ  = 2'd3
  } seq_state_t;

  localparam int unsigned SCLK_MAX_HZ = 17_000_000;
endpackage

// File: rtl/adc_tick_timer.sv
module adc_tick_timer #(
  parameter int TMR_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [TMR_W-1:0] period,
  output logic             tick
);
  logic [TMR_W-1:0] cnt_q, cnt_d;
  logic             hit;

  always_comb begin
    hit = (cnt_q == '0);
    if (hit) cnt_d = (period == '0) ? '0 : period - 1'b1;
    else     cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign tick = hit;
endmodule

// File: rtl/adc_seq_fsm.sv
module adc_seq_fsm
  import adc_rd_pkg::*;
#(
  parameter int TMR_W = 16,
  parameter int PW_W  = 8,
  parameter int OVR_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             busy,
  input  logic             rd_done,
  input  logic [PW_W-1:0]  cnv_width,
  input  logic [TMR_W-1:0] timeout_cyc,
  output logic             cnv_n,
  output logic             rd_go,
  output logic             tmo_err,
  output logic [OVR_W-1:0] ovr_cnt
);
  localparam logic [PW_W-1:0]  PW_MIN  = PW_W'(2);
  localparam logic [OVR_W-1:0] OVR_MAX = '1;

  seq_state_t       state_q, state_d;
  logic [PW_W-1:0]  pw_q, pw_d, w_eff;
  logic [TMR_W-1:0] tmo_q, tmo_d;
  logic             busy_q, fall;
  logic             err_q, err_d;
  logic [OVR_W-1:0] ovr_q, ovr_d;
  logic             cnv_n_q;

  always_comb begin
    w_eff   = (cnv_width < PW_MIN) ? PW_MIN : cnv_width;
    fall    = busy_q & ~busy;
    state_d = state_q;
    pw_d    = pw_q;
    tmo_d   = tmo_q;
    err_d   = 1'b0;
    ovr_d   = ovr_q;
    rd_go   = 1'b0;
    case (state_q)
      SEQ_IDLE: if (tick) begin
        state_d = SEQ_START;
        pw_d    = '0;
        tmo_d   = '0;
      end
      SEQ_START: begin
        pw_d  = pw_q + 1'b1;
        tmo_d = tmo_q + 1'b1;
        if (pw_q >= w_eff - 1'b1) state_d = SEQ_WAIT;
      end
      SEQ_WAIT: begin
        if (fall) begin
          rd_go   = 1'b1;
          state_d = SEQ_READ;
        end else if (tmo_q >= timeout_cyc) begin
          err_d   = 1'b1;
          state_d = SEQ_IDLE;
        end else begin
          tmo_d = tmo_q + 1'b1;
        end
      end
      SEQ_READ: if (rd_done) state_d = SEQ_IDLE;
      default:  state_d = SEQ_IDLE;
    endcase
    if (tick && (state_q != SEQ_IDLE) && (ovr_q != OVR_MAX)) ovr_d = ovr_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SEQ_IDLE;
      pw_q    <= '0;
      tmo_q   <= '0;
      busy_q  <= 1'b0;
      err_q   <= 1'b0;
      ovr_q   <= '0;
      cnv_n_q <= 1'b1;
    end else begin
      state_q <= state_d;
      pw_q    <= pw_d;
      tmo_q   <= tmo_d;
      busy_q  <= busy;
      err_q   <= err_d;
      ovr_q   <= ovr_d;
      cnv_n_q <= (state_d != SEQ_START);
    end
  end

  assign cnv_n   = cnv_n_q;
  assign tmo_err = err_q;
  assign ovr_cnt = ovr_q;

  // R3: start pulse is at least two clocks long
  p_cnv_min_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cnv_n) |-> !$past(cnv_n, 2));
  // R9: dropped-event count never goes down
  p_ovr_mono_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_cnt >= $past(ovr_cnt));
  // R8: an error pulse is a single cycle
  p_err_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    tmo_err |=> !tmo_err);
endmodule

// File: rtl/adc_spi_rx.sv
module adc_spi_rx
  import adc_rd_pkg::*;
#(
  parameter int CLK_HZ     = 100_000_000,
  parameter int SCLK_HALF  = 3,
  parameter int WORD_W     = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              sdo,
  output logic              cs_n,
  output logic              sclk,
  output logic [WORD_W-1:0] data,
  output logic              done
);
  localparam int EDGES   = 2 * WORD_W;
  localparam int EC_W    = $clog2(EDGES);
  localparam int HC_W    = (SCLK_HALF > 1) ? $clog2(SCLK_HALF) : 1;
  localparam int MIN_CYC = (CLK_HZ + SCLK_MAX_HZ - 1) / SCLK_MAX_HZ;
  localparam int GAP_W   = $clog2(MIN_CYC + 1) + 1;

  logic              act_q, act_d;
  logic              sclk_q, sclk_d;
  logic [HC_W-1:0]   hc_q, hc_d;
  logic [EC_W-1:0]   ec_q, ec_d;
  logic [WORD_W-1:0] sh_q, sh_d;
  logic [WORD_W-1:0] data_q, data_d;
  logic              done_d, done_q;
  logic              turn;

  always_comb begin
    act_d  = act_q;
    sclk_d = sclk_q;
    hc_d   = hc_q;
    ec_d   = ec_q;
    sh_d   = sh_q;
    data_d = data_q;
    done_d = 1'b0;
    turn   = (hc_q == HC_W'(SCLK_HALF - 1));
    if (!act_q) begin
      if (start) begin
        act_d  = 1'b1;
        sclk_d = 1'b0;
        hc_d   = '0;
        ec_d   = '0;
      end
    end else if (turn) begin
      hc_d   = '0;
      sclk_d = ~sclk_q;
      ec_d   = ec_q + 1'b1;
      if (sclk_q) sh_d = {sh_q[WORD_W-2:0], sdo};
      if (ec_q == EC_W'(EDGES - 1)) begin
        act_d  = 1'b0;
        done_d = 1'b1;
        data_d = {sh_q[WORD_W-2:0], sdo};
      end
    end else begin
      hc_d = hc_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      sclk_q <= 1'b0;
      hc_q   <= '0;
      ec_q   <= '0;
      sh_q   <= '0;
      data_q <= '0;
      done_q <= 1'b0;
    end else begin
      act_q  <= act_d;
      sclk_q <= sclk_d;
      hc_q   <= hc_d;
      ec_q   <= ec_d;
      sh_q   <= sh_d;
      data_q <= data_d;
      done_q <= done_d;
    end
  end

  assign cs_n = ~act_q;
  assign sclk = sclk_q;
  assign data = data_q;
  assign done = done_q;

  // clocks since the last sclk rise, saturating, for the rate check
  logic [GAP_W-1:0] gap_q;
  logic             sclk_prev;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap_q     <= GAP_W'(MIN_CYC);
      sclk_prev <= 1'b0;
    end else begin
      sclk_prev <= sclk;
      if (sclk && !sclk_prev)            gap_q <= GAP_W'(1);
      else if (gap_q < GAP_W'(MIN_CYC))  gap_q <= gap_q + 1'b1;
    end
  end

  // R10: serial clock period respects the 17 MHz ceiling
  p_sclk_rate_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk && !sclk_prev) |-> (gap_q >= GAP_W'(MIN_CYC)));
  // R5: clock is quiet while deselected
  p_sclk_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !sclk);
  // R7: strobe lasts one cycle
  p_valid_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

// File: rtl/adc_sample_reader.sv
module adc_sample_reader #(
  parameter int CLK_HZ    = 100_000_000,
  parameter int SCLK_HALF = 3,
  parameter int WORD_W    = 16,
  parameter int TMR_W     = 16,
  parameter int PW_W      = 8,
  parameter int OVR_W     = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [TMR_W-1:0]  period_cyc,
  input  logic [PW_W-1:0]   cnv_width,
  input  logic [TMR_W-1:0]  timeout_cyc,
  input  logic              busy,
  input  logic              sdo,
  output logic              cnv_n,
  output logic              cs_n,
  output logic              sclk,
  output logic [WORD_W-1:0] sample_data,
  output logic              sample_valid,
  output logic              timeout_err,
  output logic [OVR_W-1:0]  overrun_count
);
  logic tick, rd_go, rd_done;

  adc_tick_timer #(.TMR_W(TMR_W)) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .period (period_cyc),
    .tick   (tick)
  );

  adc_seq_fsm #(.TMR_W(TMR_W), .PW_W(PW_W), .OVR_W(OVR_W)) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .tick        (tick),
    .busy        (busy),
    .rd_done     (rd_done),
    .cnv_width   (cnv_width),
    .timeout_cyc (timeout_cyc),
    .cnv_n       (cnv_n),
    .rd_go       (rd_go),
    .tmo_err     (timeout_err),
    .ovr_cnt     (overrun_count)
  );

  adc_spi_rx #(.CLK_HZ(CLK_HZ), .SCLK_HALF(SCLK_HALF), .WORD_W(WORD_W)) u_rx (
    .clk   (clk),
    .rst_n (rst_n),
    .start (rd_go),
    .sdo   (sdo),
    .cs_n  (cs_n),
    .sclk  (sclk),
    .data  (sample_data),
    .done  (rd_done)
  );

  assign sample_valid = rd_done;

  // R4: no read while the converter reports busy
  p_no_read_in_conv_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_n |-> !busy);
  // R8: a timed-out attempt never selects the converter
  p_err_no_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_err |-> cs_n);
endmodule

// File: tb/sim_adc_sample_reader.sv
module sim_adc_sample_reader;
  localparam int HALF = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] period_cyc = '0;
  logic [7:0]  cnv_width = '0;
  logic [15:0] timeout_cyc = '0;
  logic        busy = 1'b0;
  logic        sdo = 1'b0;
  logic        cnv_n, cs_n, sclk, sample_valid, timeout_err;
  logic [15:0] sample_data;
  logic [7:0]  overrun_count;

  always #5 clk = ~clk;

  adc_sample_reader #(.SCLK_HALF(HALF)) u0 (
    .clk(clk), .rst_n(rst_n), .period_cyc(period_cyc), .cnv_width(cnv_width),
    .timeout_cyc(timeout_cyc), .busy(busy), .sdo(sdo), .cnv_n(cnv_n), .cs_n(cs_n),
    .sclk(sclk), .sample_data(sample_data), .sample_valid(sample_valid),
    .timeout_err(timeout_err), .overrun_count(overrun_count)
  );

  int n_chk = 0, n_fail = 0;
  int cfg_per, cfg_w, cfg_tmo, conv_c, ovr_T;
  bit resp_en, mon_en, chk_int, ovr_mode;
  logic [15:0] slave_word = '0;

  int cyc, fall_cyc, last_fall, lowcnt, accepted, cs_cnt, rise_cnt, valid_cnt, err_cnt;
  int resp_st, resp_cnt, sbit;
  bit cs_seen, drop_flag, prev_cnv, prev_cs, prev_sclk, prev_valid;

  task automatic check(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int weff();
    return (cfg_w < 2) ? 2 : cfg_w;
  endfunction
  function automatic int pe();
    return (cfg_per < 1) ? 1 : cfg_per;
  endfunction

  // converter serial output model: a new bit after each sclk rise, MSB first
  always @(posedge sclk or posedge cs_n) begin
    if (cs_n) sbit = 0;
    else begin
      #1;
      sdo = slave_word[15 - sbit];
      sbit = sbit + 1;
    end
  end

  // monitor and busy responder, all on the falling clock edge
  always @(negedge clk) begin
    if (mon_en) begin
      cyc++;
      if (drop_flag) begin
        check(cs_n == 1'b0, "R4 select after busy fall", cs_n, 0);
        drop_flag = 0;
      end
      if (prev_cnv && !cnv_n) begin
        accepted++;
        if (chk_int && last_fall >= 0)
          check(cyc - last_fall == pe(), "R2 event spacing", cyc - last_fall, pe());
        last_fall = cyc;
        fall_cyc  = cyc;
        lowcnt    = 0;
        cs_seen   = 0;
      end
      if (!cnv_n) lowcnt++;
      if (!prev_cnv && cnv_n) check(lowcnt == weff(), "R3 start width", lowcnt, weff());
      if (!cs_n) begin
        cs_cnt++;
        cs_seen = 1;
        if (sclk && !prev_sclk) rise_cnt++;
      end
      if (sample_valid) begin
        valid_cnt++;
        check(cs_n && !prev_cs, "R7 strobe with deselect", {prev_cs, cs_n}, 1);
        check(cs_cnt == 32 * HALF, "R5 select length", cs_cnt, 32 * HALF);
        check(rise_cnt == 16, "R5 sclk rises", rise_cnt, 16);
        check(sample_data == slave_word, "R6 data word", sample_data, slave_word);
        cs_cnt = 0;
        rise_cnt = 0;
      end
      if (prev_valid) check(!sample_valid, "R7 strobe width", sample_valid, 0);
      if (timeout_err) begin
        int e;
        err_cnt++;
        e = ((cfg_tmo > weff()) ? cfg_tmo : weff()) + 1;
        check(cyc - fall_cyc == e, "R8 timeout latency", cyc - fall_cyc, e);
        check(!cs_seen, "R8 no read on timeout", cs_seen, 0);
      end
      if (ovr_mode && cyc == ovr_T) begin
        int e;
        e = (ovr_T + pe() - 1) / pe() - accepted;
        if (e > 255) e = 255;
        check(overrun_count == 8'(e), "R9 overrun count", overrun_count, e);
      end
      case (resp_st)
        0: if (resp_en && !cnv_n) begin busy = 1'b1; resp_st = 1; end
        1: if (cnv_n) begin resp_cnt = conv_c; resp_st = 2; end
        default: begin
          resp_cnt--;
          if (resp_cnt == 0) begin
            busy = 1'b0;
            drop_flag = 1;
            resp_st = 0;
          end
        end
      endcase
      prev_cnv   = cnv_n;
      prev_cs    = cs_n;
      prev_sclk  = sclk;
      prev_valid = sample_valid;
    end
  end

  task automatic restart(int per, int w, int tmo, bit ren, bit cint);
    mon_en = 0;
    @(negedge clk);
    rst_n = 1'b0;
    busy = 1'b0;
    cfg_per = per; cfg_w = w; cfg_tmo = tmo;
    period_cyc = 16'(per); cnv_width = 8'(w); timeout_cyc = 16'(tmo);
    resp_en = ren; chk_int = cint; ovr_mode = 0;
    cyc = 0; accepted = 0; cs_cnt = 0; rise_cnt = 0; valid_cnt = 0; err_cnt = 0;
    lowcnt = 0; last_fall = -1; fall_cyc = 0; resp_st = 0; resp_cnt = 0;
    cs_seen = 0; drop_flag = 0; prev_cnv = 1; prev_cs = 1; prev_sclk = 0; prev_valid = 0;
    repeat (3) @(negedge clk);
    check(cnv_n && cs_n && !sclk && !sample_valid && !timeout_err && overrun_count == 0,
          "R1 reset state", {cnv_n, cs_n, sclk, sample_valid, timeout_err}, 5'b11000);
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk);
    #1 mon_en = 1;
  endtask

  task automatic wait_valid(int n);
    int v0;
    v0 = valid_cnt;
    while (valid_cnt < v0 + n) @(negedge clk);
  endtask

  initial begin
    logic [15:0] words[6];
    int widths[5];
    int tmos[4];
    int pers[3];
    words = '{16'h0000, 16'hFFFF, 16'h8001, 16'h7FFE, 16'hA5C3, 16'h5A3C};
    widths = '{0, 1, 2, 4, 7};
    tmos = '{0, 1, 4, 12};
    pers = '{0, 1, 37};
    conv_c = 5;

    // R2 R4 R5 R6 R7: data patterns at a long period
    restart(400, 3, 200, 1, 1);
    for (int i = 0; i < 6; i++) begin
      slave_word = words[i];
      wait_valid(1);
    end
    for (int i = 0; i < 16; i++) begin
      slave_word = 16'(1) << i;
      wait_valid(1);
    end

    // R3: pulse width sweep including clamped values
    for (int i = 0; i < 5; i++) begin
      restart(250, widths[i], 200, 1, 1);
      slave_word = 16'h3C00 + 16'(i);
      wait_valid(2);
    end

    // R8: busy never falls
    for (int wi = 0; wi < 2; wi++) begin
      for (int ti = 0; ti < 4; ti++) begin
        int e0;
        restart(300, (wi == 0) ? 2 : 5, tmos[ti], 0, 0);
        e0 = err_cnt;
        while (err_cnt == e0) @(negedge clk);
      end
    end

    // R9: events faster than the read, including saturation
    for (int pi = 0; pi < 3; pi++) begin
      restart(pers[pi], 2, 200, 1, 0);
      ovr_T = 700;
      ovr_mode = 1;
      while (cyc <= ovr_T) @(negedge clk);
    end

    mon_en = 0;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 200000, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule